// File: doc/BRIEF.md
# Contactless Card Poll Responder

This controller lets a chip answer like a simple contactless card of the 212 kbit/s family. It sits between a frame receiver and a frame transmitter. The receiver holds a complete frame and raises a done flag together with a CRC verdict. The controller decodes the length, command and request-code bytes of the frame. When the frame calls for a reply, the controller builds one of two fixed responses. It places the card ID it was given into the response and computes the response CRC. It then starts the transmitter a fixed number of ticks after it accepted the request.

The transmitter fetches the response one byte at a time through a combinational read port. When it reports that it has finished, the controller clears the receiver and goes back to listening. Frames that fail the CRC, frames that need no reply and unknown commands are dropped at once: the receiver is cleared and nothing is sent.

Top module: `nfcf_responder`

## Requirements
- R1: A CRC-good frame with length byte 6, command byte 0x00 and request code 0 (header byte index 6) gets a 22-byte reply. The reply has length byte 0x12 and command byte 0x01, followed by eight bytes of the POLL_PARAM parameter, most significant byte first, at indices 12 to 19.
- R2: A CRC-good frame with command byte 0x06 and a length byte above 5 gets a 33-byte reply. The reply has length byte 0x1D and command byte 0x07. Indices 12 and 13 hold 0x00, index 14 holds 0x01, and indices 15 to 30 hold READ_DATA, most significant byte first.
- R3: Reply indices 4 to 11 carry card_id, bits 63:56 first. The ID is the one present when the request was accepted; later changes to card_id do not affect the reply.
- R4: Every reply begins with 0xB2, 0x4D at indices 0 and 1. It ends with a CRC-16 (polynomial 0x1021, initial value 0) over the bytes from the length byte through the last payload byte, with the high byte first. tx_len equals the length byte plus 4.
- R5: A frame flagged with a bad CRC causes a one-cycle rx_clear pulse in the cycle after it is seen, and no reply.
- R6: tx_start rises in the cycle after the first clock edge at which tick minus the tick captured at acceptance, taken modulo 2^TICK_W, has reached REPLY_DELAY. The count keeps working when tick wraps.
- R7: A tx_done pulse during a reply causes a one-cycle rx_clear in the next cycle, and the block listens again.
- R8: From acceptance until tx_done, rx_done, the header and the CRC flag are ignored, and rx_clear stays low.
- R9: A poll with a non-zero request code, and any frame that is neither a poll nor a read request, is cleared from the receiver with no reply.
- R10: After reset, tx_start and rx_clear are low.
- R11: tx_start is a single-cycle pulse, and tx_len stays constant while a reply is pending or in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done | input | 1 | Receiver holds a complete frame |
| rx_crc_ok | input | 1 | CRC verdict for the held frame |
| rx_hdr | input | HDR_BYTES*8 | First header bytes of the frame; byte i at bits 8i+7:8i |
| rx_clear | output | 1 | Pulse that releases the receiver |
| card_id | input | 64 | Card ID to place in replies |
| tick | input | TICK_W | Free-running time base |
| tx_start | output | 1 | Pulse that starts the transmitter |
| tx_len | output | 8 | Total reply length in bytes |
| tx_rd_addr | input | 6 | Reply byte index requested by the transmitter |
| tx_rd_data | output | 8 | Reply byte at tx_rd_addr |
| tx_done | input | 1 | Transmitter finished the reply |

## Verification
The checks assume a well-behaved receiver and transmitter. The receiver keeps rx_hdr and rx_crc_ok steady while rx_done is high, and drops rx_done at the edge where it sees rx_clear. tick advances by at most one per cycle. tx_done arrives only after tx_start. The bench follows these rules: it releases rx_done when it samples rx_clear, it pulses tx_done only after it has read the whole reply, and it advances tick once per clock from a start value close to the wrap point. The only exception is deliberate: while a reply is pending, the bench toggles rx_done and changes the header and card ID, which exercises the period in which the block must not listen.

// File: rtl/nfcf_pkg.sv
// Shared constants, the request classification type and the CRC step
// used by the card poll responder. Assumes byte-wide frame access.
package nfcf_pkg;

    localparam int RSP_ADDR_W = 6;

    localparam logic [7:0] SYNC_HI      = 8'hB2;
    localparam logic [7:0] SYNC_LO      = 8'h4D;
    localparam logic [7:0] CMD_POLL     = 8'h00;
    localparam logic [7:0] CMD_POLL_RSP = 8'h01;
    localparam logic [7:0] CMD_READ     = 8'h06;
    localparam logic [7:0] CMD_READ_RSP = 8'h07;
    localparam logic [7:0] LEN_POLL_REQ = 8'h06;
    localparam logic [7:0] LEN_READ_MIN = 8'h06;
    localparam logic [7:0] LEN_POLL_RSP = 8'h12;
    localparam logic [7:0] LEN_READ_RSP = 8'h1D;
    localparam logic [15:0] CRC_POLY    = 16'h1021;

    typedef enum logic [1:0] {
        REQ_IGNORE = 2'd0,
        REQ_SILENT = 2'd1,
        REQ_POLL   = 2'd2,
        REQ_READ   = 2'd3
    } req_kind_e;

    // One byte of CRC-16, MSB of the byte first, no reflection.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in, input logic [7:0] data);
        logic [15:0] c;
        logic fb;
        c = crc_in;
        for (int b = 7; b >= 0; b--) begin
            fb = c[15] ^ data[b];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/nfcf_req_decode.sv
// Classifies a received frame from its length, command and request-code
// bytes. Purely combinational; assumes the bytes are stable while read.
module nfcf_req_decode
    import nfcf_pkg::*;
(
    input  logic [7:0] len_byte,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] code_byte,
    output req_kind_e  kind
);

    // Map header fields to the request class.
    always_comb begin
        kind = REQ_IGNORE;
        if (cmd_byte == CMD_POLL && len_byte == LEN_POLL_REQ) begin
            if (code_byte == 8'd0)      kind = REQ_POLL;
            else if (code_byte == 8'd1) kind = REQ_SILENT;
        end else if (cmd_byte == CMD_READ && len_byte >= LEN_READ_MIN) begin
            kind = REQ_READ;
        end
    end

endmodule

// File: rtl/nfcf_resp_rom.sv
// Produces any byte of the selected reply from its index: sync word,
// length, command, card ID, fixed tail and CRC. Combinational; assumes
// the CRC input is only meaningful once the CRC engine has finished.
module nfcf_resp_rom
    import nfcf_pkg::*;
#(
    parameter logic [63:0]  POLL_PARAM = 64'h0,
    parameter logic [127:0] READ_DATA  = 128'h0
) (
    input  logic                  is_read,
    input  logic [63:0]           card_id,
    input  logic [15:0]           crc,
    input  logic [RSP_ADDR_W-1:0] addr,
    output logic [7:0]            data,
    output logic [7:0]            len_byte
);

    int           a;
    int           lb;
    logic [63:0]  id_sh;
    logic [63:0]  poll_sh;
    logic [127:0] read_sh;

    assign len_byte = is_read ? LEN_READ_RSP : LEN_POLL_RSP;

    // Select the reply byte for the requested index.
    always_comb begin
        a       = int'(addr);
        lb      = int'(len_byte);
        id_sh   = card_id >> (8 * (11 - a));
        poll_sh = POLL_PARAM >> (8 * (19 - a));
        read_sh = READ_DATA >> (8 * (30 - a));
        data    = 8'h00;
        if (a == 0)            data = SYNC_HI;
        else if (a == 1)       data = SYNC_LO;
        else if (a == 2)       data = len_byte;
        else if (a == 3)       data = is_read ? CMD_READ_RSP : CMD_POLL_RSP;
        else if (a <= 11)      data = id_sh[7:0];
        else if (a == lb + 2)  data = crc[15:8];
        else if (a == lb + 3)  data = crc[7:0];
        else if (a < lb + 2) begin
            if (!is_read)      data = poll_sh[7:0];
            else if (a == 14)  data = 8'h01;
            else if (a >= 15)  data = read_sh[7:0];
        end
    end

endmodule

// File: rtl/nfcf_crc_engine.sv
// Walks the reply from the length byte to the last payload byte, one byte
// per cycle, and accumulates the CRC. Assumes its read port sees the
// latched reply selection from the cycle after start.
module nfcf_crc_engine
    import nfcf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [7:0]            len_byte,
    input  logic [7:0]            rd_data,
    output logic [RSP_ADDR_W-1:0] rd_addr,
    output logic [15:0]           crc,
    output logic                  ready
);

    logic                  busy_q;
    logic                  ready_q;
    logic [RSP_ADDR_W-1:0] addr_q;
    logic [15:0]           crc_q;

    // Sequence through the covered bytes and fold each into the CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
            addr_q  <= '0;
            crc_q   <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            ready_q <= 1'b0;
            addr_q  <= RSP_ADDR_W'(2);
            crc_q   <= '0;
        end else if (busy_q) begin
            crc_q  <= crc16_step(crc_q, rd_data);
            addr_q <= addr_q + 1'b1;
            if (8'(addr_q) == len_byte + 8'd1) begin
                busy_q  <= 1'b0;
                ready_q <= 1'b1;
            end
        end
    end

    assign rd_addr = addr_q;
    assign crc     = crc_q;
    assign ready   = ready_q;

endmodule

// File: rtl/nfcf_reply_timer.sv
// Captures the tick value when a request is accepted and flags when the
// reply delay has elapsed. Assumes tick is a wrapping up-counter.
module nfcf_reply_timer #(
    parameter int TICK_W = 16,
    parameter int DELAY  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [TICK_W-1:0] tick,
    output logic              due
);

    localparam logic [TICK_W-1:0] DELAY_T = TICK_W'(DELAY);

    logic [TICK_W-1:0] t0_q;
    logic [TICK_W-1:0] elapsed;

    // Record the reference time on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) t0_q <= '0;
        else if (arm) t0_q <= tick;
    end

    assign elapsed = tick - t0_q;
    assign due     = (elapsed >= DELAY_T);

endmodule

// File: rtl/nfcf_responder.sv
// Card poll responder: classifies each received frame, drops bad or
// unanswered ones, and for answered ones latches the card ID, computes the
// reply CRC and starts the transmitter REPLY_DELAY ticks after acceptance.
// Assumes the receiver holds its frame until rx_clear and the transmitter
// reads the reply through tx_rd_addr/tx_rd_data before raising tx_done.
module nfcf_responder
    import nfcf_pkg::*;
#(
    parameter int           TICK_W      = 16,
    parameter int           REPLY_DELAY = 512,
    parameter int           HDR_BYTES   = 8,
    parameter logic [63:0]  POLL_PARAM  = 64'h5A10_0000_0C21_7700,
    parameter logic [127:0] READ_DATA   = 128'h0100_0000_0003_0000_0000_0000_0000_0015
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_done,
    input  logic                  rx_crc_ok,
    input  logic [HDR_BYTES*8-1:0] rx_hdr,
    output logic                  rx_clear,
    input  logic [63:0]           card_id,
    input  logic [TICK_W-1:0]     tick,
    output logic                  tx_start,
    output logic [7:0]            tx_len,
    input  logic [RSP_ADDR_W-1:0] tx_rd_addr,
    output logic [7:0]            tx_rd_data,
    input  logic                  tx_done
);

    localparam int IDX_LEN  = 2;
    localparam int IDX_CMD  = 3;
    localparam int IDX_CODE = 6;

    typedef enum logic [1:0] {
        ST_LISTEN = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SEND   = 2'd2
    } state_e;

    state_e      state_q;
    req_kind_e   kind;
    logic        is_read_q;
    logic [63:0] id_q;
    logic        tx_start_q;
    logic        rx_clear_q;
    logic        frame_seen;
    logic        accept;
    logic        listening;
    logic        sending;
    logic        due;
    logic        crc_ready;
    logic [15:0] crc;
    logic [RSP_ADDR_W-1:0] crc_addr;
    logic [7:0]  crc_byte;
    logic [7:0]  rsp_len_a;
    logic [7:0]  rsp_len_b;

    nfcf_req_decode dec_i (
        .len_byte  (rx_hdr[IDX_LEN*8 +: 8]),
        .cmd_byte  (rx_hdr[IDX_CMD*8 +: 8]),
        .code_byte (rx_hdr[IDX_CODE*8 +: 8]),
        .kind      (kind)
    );

    assign listening  = (state_q == ST_LISTEN);
    assign sending    = (state_q == ST_SEND);
    assign frame_seen = listening && rx_done && !rx_clear_q;
    assign accept     = frame_seen && rx_crc_ok && (kind == REQ_POLL || kind == REQ_READ);

    // Main control: accept, drop, schedule and finish replies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_LISTEN;
            is_read_q  <= 1'b0;
            id_q       <= '0;
            tx_start_q <= 1'b0;
            rx_clear_q <= 1'b0;
        end else begin
            tx_start_q <= 1'b0;
            rx_clear_q <= 1'b0;
            case (state_q)
                ST_LISTEN: begin
                    if (accept) begin
                        is_read_q <= (kind == REQ_READ);
                        id_q      <= card_id;
                        state_q   <= ST_ARMED;
                    end else if (frame_seen) begin
                        rx_clear_q <= 1'b1;
                    end
                end
                ST_ARMED: begin
                    if (crc_ready && due) begin
                        tx_start_q <= 1'b1;
                        state_q    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_done) begin
                        rx_clear_q <= 1'b1;
                        state_q    <= ST_LISTEN;
                    end
                end
                default: state_q <= ST_LISTEN;
            endcase
        end
    end

    nfcf_reply_timer #(
        .TICK_W (TICK_W),
        .DELAY  (REPLY_DELAY)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (accept),
        .tick  (tick),
        .due   (due)
    );

    nfcf_resp_rom #(
        .POLL_PARAM (POLL_PARAM),
        .READ_DATA  (READ_DATA)
    ) rom_crc_i (
        .is_read  (is_read_q),
        .card_id  (id_q),
        .crc      (16'h0000),
        .addr     (crc_addr),
        .data     (crc_byte),
        .len_byte (rsp_len_a)
    );

    nfcf_crc_engine crc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .len_byte (rsp_len_a),
        .rd_data  (crc_byte),
        .rd_addr  (crc_addr),
        .crc      (crc),
        .ready    (crc_ready)
    );

    nfcf_resp_rom #(
        .POLL_PARAM (POLL_PARAM),
        .READ_DATA  (READ_DATA)
    ) rom_tx_i (
        .is_read  (is_read_q),
        .card_id  (id_q),
        .crc      (crc),
        .addr     (tx_rd_addr),
        .data     (tx_rd_data),
        .len_byte (rsp_len_b)
    );

    assign tx_len   = rsp_len_b + 8'd4;
    assign tx_start = tx_start_q;
    assign rx_clear = rx_clear_q;

endmodule

// File: rtl/nfcf_responder_chk.sv
// Property checker for the card poll responder, attached by bind. Keeps
// its own copy of the acceptance tick to judge reply timing.
module nfcf_responder_chk #(
    parameter int TICK_W = 16,
    parameter int DELAY  = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_done,
    input logic              rx_crc_ok,
    input logic              rx_clear,
    input logic              tx_start,
    input logic              tx_done,
    input logic [7:0]        tx_len,
    input logic [TICK_W-1:0] tick,
    input logic              accept,
    input logic              listening,
    input logic              sending
);

    logic [TICK_W-1:0] t0_q;

    // Reference time captured on each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) t0_q <= '0;
        else if (accept) t0_q <= tick;
    end

    // R5: bad-CRC frame is released next cycle and no reply is pending.
    a_r5_bad_crc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (listening && rx_done && !rx_crc_ok && !rx_clear) |=> (rx_clear && listening));

    // R11: start is a single-cycle pulse.
    a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R6: never start before the delay has elapsed.
    a_r6_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (TICK_W'($past(tick) - t0_q) >= TICK_W'(DELAY)));

    // R7: transmitter completion releases the receiver and resumes listening.
    a_r7_clear_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && tx_done) |=> (rx_clear && listening));

    // R8: no receiver release while a reply is pending or in progress.
    a_r8_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !listening |-> !rx_clear);

    // R11: reply length does not move while busy.
    a_r11_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!listening && $past(!listening)) |-> $stable(tx_len));

    // R4: only the two reply lengths are ever started.
    a_r4_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (tx_len == 8'd22 || tx_len == 8'd33));

endmodule

bind nfcf_responder nfcf_responder_chk #(
    .TICK_W (TICK_W),
    .DELAY  (REPLY_DELAY)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_done   (rx_done),
    .rx_crc_ok (rx_crc_ok),
    .rx_clear  (rx_clear),
    .tx_start  (tx_start),
    .tx_done   (tx_done),
    .tx_len    (tx_len),
    .tick      (tick),
    .accept    (accept),
    .listening (listening),
    .sending   (sending)
);

// File: tb/nfcf_responder_tb_top.sv
// Sweeps command, length, request code and CRC verdict; models receiver
// and transmitter handshakes; computes every reply byte and CRC itself.
module nfcf_responder_tb_top;

    localparam int           CLK_PERIOD = 10;
    localparam int           TICK_W     = 16;
    localparam int           DELAY      = 512;
    localparam logic [63:0]  POLL_P     = 64'hC3A5_1E00_7F42_0899;
    localparam logic [127:0] READ_D     = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     rx_done = 1'b0;
    logic                     rx_crc_ok = 1'b0;
    logic [63:0]              rx_hdr = '0;
    logic                     rx_clear;
    logic [63:0]              card_id = '0;
    logic [TICK_W-1:0]        tick;
    logic                     tx_start;
    logic [7:0]               tx_len;
    logic [5:0]               tx_rd_addr = '0;
    logic [7:0]               tx_rd_data;
    logic                     tx_done = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Time base: one tick per clock, starting near the wrap point.
    always @(posedge clk) begin
        if (!rst_n) tick <= 16'hFE80;
        else        tick <= tick + 1'b1;
    end

    nfcf_responder #(
        .TICK_W      (TICK_W),
        .REPLY_DELAY (DELAY),
        .HDR_BYTES   (8),
        .POLL_PARAM  (POLL_P),
        .READ_DATA   (READ_D)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_done    (rx_done),
        .rx_crc_ok  (rx_crc_ok),
        .rx_hdr     (rx_hdr),
        .rx_clear   (rx_clear),
        .card_id    (card_id),
        .tick       (tick),
        .tx_start   (tx_start),
        .tx_len     (tx_len),
        .tx_rd_addr (tx_rd_addr),
        .tx_rd_data (tx_rd_data),
        .tx_done    (tx_done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] make_hdr(input logic [7:0] len, input logic [7:0] cmd, input logic [7:0] code);
        return {8'h00, code, 8'h5C, 8'hE7, cmd, len, 8'h4D, 8'hB2};
    endfunction

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int b = 0; b < 8; b++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic run_case(input logic [7:0] cmd, input logic [7:0] len, input logic [7:0] code,
                            input bit good, input logic [63:0] id);
        bit                reply;
        bit                rd;
        bit                got;
        bit                quiet;
        int                L;
        logic [TICK_W-1:0] t0;
        logic [TICK_W-1:0] ts;
        logic [TICK_W-1:0] te;
        logic [15:0]       c;
        logic [7:0]        ef [0:40];
        string             tag;
        reply = good && ((cmd == 8'h00 && len == 8'd6 && code == 8'd0) || (cmd == 8'h06 && len > 8'd5));
        rd    = (cmd == 8'h06);
        ts    = '0;
        @(negedge clk);
        rx_hdr    = make_hdr(len, cmd, code);
        rx_crc_ok = good;
        card_id   = id;
        rx_done   = 1'b1;
        t0        = tick;
        if (!reply) begin
            tag = good ? "R9" : "R5";
            got = 1'b0;
            for (int k = 0; k < 4 && !got; k++) begin
                @(negedge clk);
                if (rx_clear) got = 1'b1;
            end
            rx_done = 1'b0;
            check(got, tag, 32'(got), 32'd1);
            got = 1'b0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (tx_start) got = 1'b1;
            end
            check(!got, tag, 32'(got), 32'd0);
        end else begin
            tag   = rd ? "R2" : "R1";
            got   = 1'b0;
            quiet = 1'b1;
            for (int k = 0; k < 700 && !got; k++) begin
                @(negedge clk);
                if (rx_clear) quiet = 1'b0;
                if (tx_start) begin
                    got = 1'b1;
                    ts  = tick;
                end
                if (k == 100) begin
                    rx_done = 1'b0;
                    card_id = ~id;
                    rx_hdr  = rd ? make_hdr(8'd6, 8'h00, 8'd0) : make_hdr(8'd16, 8'h06, 8'd0);
                end
                if (k == 101) rx_done = 1'b1;
            end
            check(quiet, "R8", 32'(quiet), 32'd1);
            check(got, tag, 32'(got), 32'd1);
            te = TICK_W'(t0 + DELAY + 1);
            check(ts == te, "R6", 32'(ts), 32'(te));
            L = rd ? 29 : 18;
            check(tx_len == 8'(L + 4), rd ? "R2" : "R4", 32'(tx_len), 32'(L + 4));
            ef[0] = 8'hB2;
            ef[1] = 8'h4D;
            ef[2] = 8'(L);
            ef[3] = rd ? 8'h07 : 8'h01;
            for (int i = 0; i < 8; i++) ef[4 + i] = id[63 - 8*i -: 8];
            if (rd) begin
                ef[12] = 8'h00;
                ef[13] = 8'h00;
                ef[14] = 8'h01;
                for (int i = 0; i < 16; i++) ef[15 + i] = READ_D[127 - 8*i -: 8];
            end else begin
                for (int i = 0; i < 8; i++) ef[12 + i] = POLL_P[63 - 8*i -: 8];
            end
            c = 16'h0000;
            for (int i = 2; i < L + 2; i++) c = crc_byte(c, ef[i]);
            ef[L + 2] = c[15:8];
            ef[L + 3] = c[7:0];
            for (int a = 0; a < L + 4; a++) begin
                tx_rd_addr = 6'(a);
                #1;
                if (a >= 4 && a <= 11)          tag = "R3";
                else if (a < 2 || a >= L + 2)   tag = "R4";
                else                            tag = rd ? "R2" : "R1";
                check(tx_rd_data == ef[a], tag, 32'(tx_rd_data), 32'(ef[a]));
            end
            @(negedge clk);
            tx_done = 1'b1;
            @(negedge clk);
            tx_done = 1'b0;
            check(rx_clear == 1'b1, "R7", 32'(rx_clear), 32'd1);
            rx_done = 1'b0;
            @(negedge clk);
            check(rx_clear == 1'b0 && tx_start == 1'b0, "R11", 32'({rx_clear, tx_start}), 32'd0);
        end
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Main stimulus.
    initial begin
        logic [7:0] cmds  [0:4];
        logic [7:0] lens  [0:4];
        int n;
        cmds[0] = 8'h00; cmds[1] = 8'h01; cmds[2] = 8'h06; cmds[3] = 8'h07; cmds[4] = 8'hFF;
        lens[0] = 8'd4;  lens[1] = 8'd5;  lens[2] = 8'd6;  lens[3] = 8'd7;  lens[4] = 8'd16;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_start == 1'b0 && rx_clear == 1'b0, "R10", 32'({tx_start, rx_clear}), 32'd0);
        // Early poll: the reply delay spans the tick wrap (R6).
        run_case(8'h00, 8'd6, 8'd0, 1'b1, 64'h0011_2233_4455_6677);
        n = 0;
        for (int ci = 0; ci < 5; ci++) begin
            for (int li = 0; li < 5; li++) begin
                for (int q = 0; q < 3; q++) begin
                    for (int g = 0; g < 2; g++) begin
                        run_case(cmds[ci], lens[li], 8'(q), g[0],
                                 64'h0123_4567_89AB_CDEF ^ {8{8'(n * 29 + 3)}});
                        n++;
                    end
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule